// File: doc/BRIEF.md
# Fractional-Rate Timebase Counter

This block keeps a free-running 64-bit time count whose rate is a fractional fraction of an input enable stream. On every cycle in which the selected enable is high, a fixed increment of 2^31 is added to a 33-bit phase accumulator. When the accumulator reaches the programmed divisor, the divisor is subtracted and one tick is issued. Each tick advances the count by one, or by two when the double-step control bit is set. The resulting tick rate is the enable rate times 2^31 divided by the divisor. A divisor of 0x8000_0000 gives exactly one tick per enabled cycle.

Software sets the block up through a single-cycle register port. A control register chooses the enable source and the step size. A 32-bit divisor register sets the rate. Two word-wide windows read or preset the count. The high word is captured when the low word is read, so a low-then-high read pair always returns one coherent 64-bit value. The live count is also driven on an output port for local consumers.

Top module: `frac_timebase`

## Requirements
- R1: After a synchronous active-low reset, the control register reads 0, the divisor reads 0x8000_0000, the count is 0 and the phase accumulator is 0.
- R2: Control bit 8 selects the enable source. When the bit is 0, `xtal_en` advances the phase and `core_en` is ignored. When the bit is 1, `core_en` advances the phase and `xtal_en` is ignored.
- R3: Control bit 9 sets the step. When it is 0, each tick adds 1 to the count. When it is 1, each tick adds 2.
- R4: On each enabled cycle the accumulator gains 2^31. If the result is at or above the effective divisor, the divisor is subtracted and a tick occurs. Starting from reset with divisor 0xC000_0000, 30 enabled cycles give 20 ticks.
- R5: With the default divisor 0x8000_0000, every enabled cycle produces exactly one tick.
- R6: A written divisor below 0x8000_0000 is used as 0x8000_0000. The register still reads back the value that was written, and no more than one tick occurs per cycle.
- R7: The count changes only on the clock edge after a tick, or on a count write. On any other cycle it holds.
- R8: A read at offset 0x20 returns count bits [31:0] and captures count bits [63:32]. A read at offset 0x24 returns the captured high word, even if the count has moved since the capture.
- R9: Register map: control at offset 0x00, with only bits 9:8 stored and all other bits reading 0; divisor at offset 0x08, full 32 bits. Unmapped offsets read 0, and writes to them have no effect. Read data appears on `bus_rdata` on the edge after `bus_rd` and then holds.
- R10: A write at offset 0x20 or 0x24 replaces the low or high count word on the next edge. In that cycle the write takes priority over a tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xtal_en | input | 1 | Reference-clock enable (source 0) |
| core_en | input | 1 | Alternate core-clock enable (source 1) |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| count | output | 64 | Live time count |

## Verification
The bench targets the following corner cases, and what a faulty design would do in each:
- **Fractional ratio.** The bench programs a divisor of 0xC000_0000 and expects exactly 20 ticks in 30 enabled cycles. A design that compares with the wrong sense, or that drops the remainder, gives 15 or 30.
- **Divisor clamp.** The bench writes a tiny divisor. A design without the clamp would need to tick several times per cycle, and its count would run away.
- **Source selection.** The bench drives only the deselected enable. A design that ORs the two sources, or swaps them, moves the count.
- **Low/high read pair.** The bench presets the count just below a 32-bit carry, reads the low word, lets ticks carry into the high word, and then reads the high word. A design that returns the live high word shows the carried value instead of the captured one.
- **Random traffic.** Random traffic mixes all of these with step changes and count presets against a cycle-accurate bench model.

// File: rtl/ftb_pkg.sv
// Shared constants for the fractional timebase: bus widths, the register
// map and the positions of the control bits.
// Assumes a 32-bit register port with byte offsets.
package ftb_pkg;
    localparam int BUS_W   = 32;
    localparam int ADDR_W  = 8;
    localparam int SEL_BIT = 8;    // enable-source select
    localparam int DBL_BIT = 9;    // double step
    localparam logic [ADDR_W-1:0] OFF_CTRL   = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_DIV    = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_CNT_LO = 8'h20;
    localparam logic [ADDR_W-1:0] OFF_CNT_HI = 8'h24;
    localparam logic [BUS_W-1:0]  DIV_RESET  = 32'h8000_0000;
endpackage

// File: rtl/ftb_regs.sv
// Register file for the timebase: holds the control bits and the divisor,
// decodes count-word writes and the low-word read, and registers read data.
// Assumes single-cycle strobes; bus_wr and bus_rd are not both high.
module ftb_regs
    import ftb_pkg::*;
#(
    parameter int DW = BUS_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] cnt_lo,
    input  logic [DW-1:0] shadow_hi,
    output logic [DW-1:0] bus_rdata,
    output logic          src_sel,
    output logic          dbl_step,
    output logic [DW-1:0] div_eff,
    output logic          wr_lo,
    output logic          wr_hi,
    output logic          rd_lo
);
    localparam logic [DW-1:0] DIV_MIN = DW'(1) << (DW - 1);

    logic          sel_q, dbl_q;
    logic [DW-1:0] div_q;
    logic [DW-1:0] rd_mux;

    // Control and divisor registers, written through the port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= 1'b0;
            dbl_q <= 1'b0;
            div_q <= DIV_RESET;
        end else if (bus_wr) begin
            if (bus_addr == OFF_CTRL) begin
                sel_q <= bus_wdata[SEL_BIT];
                dbl_q <= bus_wdata[DBL_BIT];
            end
            if (bus_addr == OFF_DIV) div_q <= bus_wdata;
        end
    end

    // Read-data multiplexer over the visible registers.
    always_comb begin
        rd_mux = '0;
        case (bus_addr)
            OFF_CTRL: begin
                rd_mux[SEL_BIT] = sel_q;
                rd_mux[DBL_BIT] = dbl_q;
            end
            OFF_DIV:    rd_mux = div_q;
            OFF_CNT_LO: rd_mux = cnt_lo;
            OFF_CNT_HI: rd_mux = shadow_hi;
            default:    rd_mux = '0;
        endcase
    end

    // Read data is registered on a read strobe and held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end

    // Effective divisor never drops below 2^(DW-1).
    always_comb div_eff = (div_q < DIV_MIN) ? DIV_MIN : div_q;

    assign src_sel  = sel_q;
    assign dbl_step = dbl_q;
    assign wr_lo    = bus_wr && (bus_addr == OFF_CNT_LO);
    assign wr_hi    = bus_wr && (bus_addr == OFF_CNT_HI);
    assign rd_lo    = bus_rd && (bus_addr == OFF_CNT_LO);

    // R9: a divisor write is visible in the next cycle.
    a_r9_div_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFF_DIV) |=> (div_q == $past(bus_wdata)));
    // R9: reads of unmapped offsets return zero.
    a_r9_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr != OFF_CTRL && bus_addr != OFF_DIV &&
         bus_addr != OFF_CNT_LO && bus_addr != OFF_CNT_HI) |=> (bus_rdata == '0));
    // R9: read data holds when no read strobe is given.
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
endmodule

// File: rtl/ftb_phase.sv
// Phase accumulator: on each enabled cycle adds INCR; when the sum reaches
// the effective divisor it subtracts the divisor and raises tick for that
// cycle.
// Assumes div_eff >= INCR, so one subtraction always brings the sum back in range.
module ftb_phase #(
    parameter int DW   = 32,
    parameter int PW   = DW + 1,
    parameter logic [PW-1:0] INCR = PW'(1) << (DW - 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [DW-1:0] div_eff,
    output logic          tick
);
    logic [PW-1:0] acc_q, sum, div_ext;

    // Candidate sum and compare against the divisor.
    always_comb begin
        div_ext = PW'(div_eff);
        sum     = acc_q + INCR;
        tick    = en && (sum >= div_ext);
    end

    // Accumulator update: add on enable, subtract the divisor on a tick.
    always_ff @(posedge clk) begin
        if (!rst_n)    acc_q <= '0;
        else if (tick) acc_q <= sum - div_ext;
        else if (en)   acc_q <= sum;
    end

    // R6: the effective divisor seen here is never below the increment.
    a_r6_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        PW'(div_eff) >= INCR);
    // R4: the accumulator never needs its top bit after an update.
    a_r4_acc_bound: assert property (@(posedge clk) disable iff (!rst_n)
        acc_q[PW-1] == 1'b0);
    // R7: no tick without an enable.
    a_r7_tick_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> en);
endmodule

// File: rtl/ftb_count.sv
// The 64-bit time count with word presets and a captured high word for
// coherent two-word reads.
// Assumes a preset and a tick in the same cycle resolve in favour of the preset.
module ftb_count #(
    parameter int DW = 32,
    parameter int CW = 2 * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          dbl_step,
    input  logic          wr_lo,
    input  logic          wr_hi,
    input  logic          rd_lo,
    input  logic [DW-1:0] wdata,
    output logic [CW-1:0] cnt_q,
    output logic [DW-1:0] shadow_hi
);
    logic [CW-1:0] step;

    // Step size chosen by the control bit.
    always_comb step = dbl_step ? CW'(2) : CW'(1);

    // Count register: presets first, then ticks.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= '0;
        else if (wr_lo) cnt_q <= {cnt_q[CW-1:DW], wdata};
        else if (wr_hi) cnt_q <= {wdata, cnt_q[DW-1:0]};
        else if (tick)  cnt_q <= cnt_q + step;
    end

    // Capture of the high word when the low word is read.
    always_ff @(posedge clk) begin
        if (!rst_n)     shadow_hi <= '0;
        else if (rd_lo) shadow_hi <= cnt_q[CW-1:DW];
    end

    // R7: the count holds without a tick or a preset.
    a_r7_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_lo && !wr_hi) |=> $stable(cnt_q));
    // R3: a tick adds the selected step.
    a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_lo && !wr_hi) |=>
            (cnt_q == $past(cnt_q) + ($past(dbl_step) ? CW'(2) : CW'(1))));
    // R8: a low-word read captures the high word of that cycle.
    a_r8_capture: assert property (@(posedge clk) disable iff (!rst_n)
        rd_lo |=> (shadow_hi == $past(cnt_q[CW-1:DW])));
    // R10: a low-word preset lands regardless of a tick.
    a_r10_preset: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> (cnt_q[DW-1:0] == $past(wdata)));
endmodule

// File: rtl/frac_timebase.sv
// Top of the fractional timebase: selects the enable source, runs the
// phase accumulator and advances the 64-bit count behind a register port.
// Assumes both enables are already synchronous to clk.
module frac_timebase
    import ftb_pkg::*;
#(
    parameter int DW = BUS_W,
    parameter int AW = ADDR_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            xtal_en,
    input  logic            core_en,
    input  logic            bus_wr,
    input  logic            bus_rd,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    output logic [2*DW-1:0] count
);
    localparam int CW = 2 * DW;

    logic          src_sel, dbl_step, wr_lo, wr_hi, rd_lo, en, tick;
    logic [DW-1:0] div_eff, shadow_hi;
    logic [CW-1:0] cnt_q;

    ftb_regs #(.DW(DW), .AW(AW)) i_regs (
        .clk, .rst_n, .bus_wr, .bus_rd, .bus_addr, .bus_wdata,
        .cnt_lo(cnt_q[DW-1:0]), .shadow_hi, .bus_rdata,
        .src_sel, .dbl_step, .div_eff, .wr_lo, .wr_hi, .rd_lo
    );

    // Enable-source selection.
    always_comb en = src_sel ? core_en : xtal_en;

    ftb_phase #(.DW(DW)) i_phase (
        .clk, .rst_n, .en, .div_eff, .tick
    );

    ftb_count #(.DW(DW)) i_count (
        .clk, .rst_n, .tick, .dbl_step, .wr_lo, .wr_hi, .rd_lo,
        .wdata(bus_wdata), .cnt_q, .shadow_hi
    );

    assign count = cnt_q;

    // R2: a tick only ever follows the selected source.
    a_r2_source: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (src_sel ? core_en : xtal_en));
    // R5: at the minimum divisor every enabled cycle ticks.
    a_r5_one_to_one: assert property (@(posedge clk) disable iff (!rst_n)
        (en && div_eff == (DW'(1) << (DW - 1))) |-> tick);
endmodule

// File: tb/test_frac_timebase.sv
module test_frac_timebase;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        xtal_en = 0, core_en = 0, bus_wr = 0, bus_rd = 0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [63:0] count;

    int checks = 0, errors = 0;
    bit done = 0;

    // Bench model of the state
    logic [63:0] m_cnt, m_shadow;
    logic [32:0] m_acc;
    logic [31:0] m_div;
    bit          m_sel, m_dbl;

    frac_timebase i_frac_timebase (
        .clk, .rst_n, .xtal_en, .core_en, .bus_wr, .bus_rd, .bus_addr,
        .bus_wdata, .bus_rdata, .count
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] eff_div(logic [31:0] d);
        return (d < 32'h8000_0000) ? 32'h8000_0000 : d;
    endfunction

    function automatic logic [31:0] exp_read(logic [7:0] a);
        case (a)
            8'h00: return {22'b0, m_dbl, m_sel, 8'b0};
            8'h08: return m_div;
            8'h20: return m_cnt[31:0];
            8'h24: return m_shadow[31:0];
            default: return 32'h0;
        endcase
    endfunction

    // One clock cycle of stimulus; the model advances with the design and
    // count (plus read data on a read) is compared after the edge.
    task automatic cyc(bit xe, bit ce, bit we, bit re, logic [7:0] a,
                       logic [31:0] d, string req);
        logic [32:0] sum;
        bit          en, tk;
        logic [31:0] rexp;
        @(negedge clk);
        xtal_en = xe; core_en = ce; bus_wr = we; bus_rd = re;
        bus_addr = a; bus_wdata = d;
        en   = m_sel ? ce : xe;
        sum  = m_acc + 33'h0_8000_0000;
        tk   = en && (sum >= {1'b0, eff_div(m_div)});
        rexp = exp_read(a);
        @(posedge clk);
        #1;
        if (re && a == 8'h20) m_shadow = {32'b0, m_cnt[63:32]};
        if (we && a == 8'h20)      m_cnt[31:0]  = d;
        else if (we && a == 8'h24) m_cnt[63:32] = d;
        else if (tk)               m_cnt = m_cnt + (m_dbl ? 64'd2 : 64'd1);
        if (tk)      m_acc = sum - {1'b0, eff_div(m_div)};
        else if (en) m_acc = sum;
        if (we && a == 8'h00) begin m_sel = d[8]; m_dbl = d[9]; end
        if (we && a == 8'h08) m_div = d;
        chk({req, " count"}, count, m_cnt);
        if (re) chk({req, " rdata"}, {32'b0, bus_rdata}, {32'b0, rexp});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; xtal_en = 0; core_en = 0; bus_wr = 0; bus_rd = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        m_cnt = '0; m_shadow = '0; m_acc = '0; m_div = 32'h8000_0000;
        m_sel = 0; m_dbl = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [63:0] start;
        void'($urandom(32'h5eed_1234));
        do_reset();
        // R1: reset state
        chk("R1 count", count, 64'h0);
        cyc(0, 0, 0, 1, 8'h00, 0, "R1 ctrl");
        cyc(0, 0, 0, 1, 8'h08, 0, "R1 div");
        chk("R1 div value", {32'b0, bus_rdata}, 64'h8000_0000);

        // R5: default ratio ticks every enabled cycle
        start = count;
        for (int i = 0; i < 50; i++) cyc(1, 0, 0, 0, 8'h00, 0, "R5");
        chk("R5 50 ticks", count - start, 64'd50);

        // R2: the deselected source is ignored
        start = count;
        for (int i = 0; i < 20; i++) cyc(0, 1, 0, 0, 8'h00, 0, "R2 core ignored");
        chk("R2 core ignored", count, start);
        cyc(0, 0, 1, 0, 8'h00, 32'h100, "R2 select core");
        start = count;
        for (int i = 0; i < 20; i++) cyc(1, 0, 0, 0, 8'h00, 0, "R2 xtal ignored");
        chk("R2 xtal ignored", count, start);
        for (int i = 0; i < 10; i++) cyc(0, 1, 0, 0, 8'h00, 0, "R2 core counts");
        chk("R2 core counts", count - start, 64'd10);

        // R3: double step
        cyc(0, 0, 1, 0, 8'h00, 32'h300, "R3 set");
        start = count;
        for (int i = 0; i < 10; i++) cyc(0, 1, 0, 0, 8'h00, 0, "R3");
        chk("R3 step two", count - start, 64'd20);

        // R9: control readback keeps only bits 9:8; unmapped reads 0
        cyc(0, 0, 1, 0, 8'h00, 32'hFFFF_FCFF, "R9 wr");
        cyc(0, 0, 0, 1, 8'h00, 0, "R9 ctrl");
        chk("R9 ctrl bits", {32'b0, bus_rdata}, 64'h0);
        cyc(0, 0, 1, 0, 8'h30, 32'hDEAD_BEEF, "R9 unmapped wr");
        cyc(0, 0, 0, 1, 8'h30, 0, "R9 unmapped rd");

        // R4: ratio 2/3 from reset
        do_reset();
        cyc(0, 0, 1, 0, 8'h08, 32'hC000_0000, "R4 div");
        for (int i = 0; i < 30; i++) cyc(1, 0, 0, 0, 8'h00, 0, "R4");
        chk("R4 20 ticks in 30", count, 64'd20);

        // R6: small divisor clamps to one tick per cycle
        do_reset();
        cyc(0, 0, 1, 0, 8'h08, 32'h0000_0010, "R6 div");
        cyc(0, 0, 0, 1, 8'h08, 0, "R6 readback");
        for (int i = 0; i < 25; i++) cyc(1, 0, 0, 0, 8'h00, 0, "R6");
        chk("R6 one per cycle", count, 64'd25);

        // R8 and R10: preset near a carry, read low, carry, read high
        do_reset();
        cyc(0, 0, 1, 0, 8'h24, 32'h0000_0007, "R10 hi");
        cyc(0, 0, 1, 0, 8'h20, 32'hFFFF_FFFE, "R10 lo");
        chk("R10 preset", count, 64'h0000_0007_FFFF_FFFE);
        cyc(1, 0, 1, 0, 8'h20, 32'hFFFF_FFFD, "R10 write beats tick");
        chk("R10 priority", count, 64'h0000_0007_FFFF_FFFD);
        cyc(0, 0, 0, 1, 8'h20, 0, "R8 lo");
        for (int i = 0; i < 6; i++) cyc(1, 0, 0, 0, 8'h00, 0, "R8 carry");
        chk("R8 carried", count[63:32], 64'h8);
        cyc(0, 0, 0, 1, 8'h24, 0, "R8 hi");
        chk("R8 captured hi", {32'b0, bus_rdata}, 64'h7);

        // Random traffic against the model (R2..R10)
        do_reset();
        for (int i = 0; i < 4000; i++) begin
            int unsigned r = $urandom_range(0, 99);
            logic [7:0] a;
            logic [31:0] d;
            case ($urandom_range(0, 4))
                0: a = 8'h00; 1: a = 8'h08; 2: a = 8'h20; 3: a = 8'h24;
                default: a = 8'h30;
            endcase
            d = $urandom;
            if (a == 8'h08 && $urandom_range(0, 3) != 0) d[31] = 1'b1;
            if (r < 6)
                cyc($urandom_range(0, 1), $urandom_range(0, 1), 1, 0, a, d, "R7 random wr");
            else if (r < 20)
                cyc($urandom_range(0, 1), $urandom_range(0, 1), 0, 1, a, 0, "R8 random rd");
            else
                cyc($urandom_range(0, 1), $urandom_range(0, 1), 0, 0, a, 0, "R4 random");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule